// File: doc/BRIEF.md
# Serial Frame Receive Deserializer

This block sits behind the line decoder of a 10 Mb/s style receiver. It takes a recovered serial bit stream, a clock that marks each bit, and a carrier-present input. While carrier is present it searches the stream for the start-of-frame delimiter. Once the delimiter is found, byte boundaries are fixed. From then on, every eight bits become one byte, and that byte is written into a small first-word-fall-through byte FIFO. A frame byte count runs alongside, and each bit after the delimiter is passed on to an external CRC checker.

The first six bytes of every frame form the destination address. The block compares them with a 48-bit station address and with the all-ones broadcast address. If neither matches, the FIFO is emptied and the rest of the frame is ignored until carrier goes away. A loss of carrier ends the frame at any point, throws away any half-built byte, and signals the frame end with a single-cycle pulse. A byte that completes while the FIFO is full is lost, and this is recorded in an overflow flag.

Top module: `rx_deserializer`

## Requirements
- R1: Bits are taken in only on clock edges where `crs` is high. An edge with `crs` low returns the block to delimiter search and clears the search window, so stimulus without carrier changes neither the FIFO nor `crc_en`.
- R2: The delimiter is found when the last eight bits, in arrival order, are 1,0,1,0,1,0,1,1 (the byte 0xD5 sent LSB first). A delimiter that is split by a carrier gap is not found. Finding a delimiter clears `byte_cnt` and `overflow`.
- R3: After the delimiter, each group of eight bits forms one byte. The first bit to arrive becomes bit 0. The byte is written to the FIFO at the edge that takes its eighth bit.
- R4: The FIFO holds 16 bytes and `rd_data` always shows the oldest byte. `rd_en` pops one byte when the FIFO is not empty. `fifo_level` gives the number of stored bytes, and `fifo_empty` is high when that number is 0.
- R5: `byte_cnt` goes up by one for each byte written to the FIFO. It is set to 0 when a delimiter is found and when a frame is rejected, and it is 0 after reset.
- R6: Frame byte k (k = 0..5) is compared with `station_addr[8k+7:8k]`. The frame is accepted if all six bytes match, or if all six bytes are 0xFF.
- R7: A frame that is not accepted empties the whole FIFO, including bytes left over from earlier frames, at the edge of its sixth byte. That sixth byte and every later byte of the frame are not stored.
- R8: When carrier drops after a delimiter, any partial byte is discarded. `frame_end` is high for exactly the one cycle after the edge that sees `crs` low.
- R9: A byte that completes while the FIFO holds 16 bytes is lost. `overflow` is then set and stays set until the next delimiter.
- R10: Each bit taken in after the delimiter of a frame that is still being stored appears on `crc_dat`, with `crc_en` high, one cycle after the bit's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crs | input | 1 | Carrier present |
| rxd | input | 1 | Serial receive data |
| station_addr | input | 48 | Station address; byte 0 in bits 7:0 |
| rd_en | input | 1 | Pop the oldest FIFO byte |
| rd_data | output | 8 | Oldest FIFO byte |
| fifo_empty | output | 1 | FIFO holds no bytes |
| fifo_level | output | 5 | Number of stored bytes |
| byte_cnt | output | 11 | Bytes written in the current frame |
| overflow | output | 1 | A byte was lost to a full FIFO |
| frame_end | output | 1 | One-cycle pulse when carrier drops during a frame |
| crc_en | output | 1 | `crc_dat` carries a frame bit |
| crc_dat | output | 1 | Forwarded frame bit |

## Verification
The hardest case to reach is the reject flush that also has to remove bytes left by an earlier accepted frame. The stimulus first leaves an accepted frame unread in the FIFO. It then sends a frame whose fourth address byte is wrong and checks that the FIFO drops to empty exactly at the sixth byte. It also checks that the bytes that follow neither enter the FIFO nor reach the CRC outputs. The split delimiter is reached by a single carrier-low cycle placed in the middle of the 0xD5 bits.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_DATA = 2'd1,
    ST_DROP = 2'd2
  } rx_state_e;

  localparam logic [7:0] SFD_OCTET   = 8'hD5;
  localparam int unsigned ADDR_OCTETS = 6;

  // serial arrival is LSB first: the newest bit enters at the top
  function automatic logic [7:0] push_bit(input logic [7:0] win, input logic b);
    return {b, win[7:1]};
  endfunction

  function automatic logic [7:0] addr_octet(input logic [47:0] a, input int unsigned k);
    return a[8*k +: 8];
  endfunction

endpackage

// File: rtl/rxd_framer.sv
module rxd_framer
  import rxd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       crs,
  input  logic       rxd,
  input  logic       drop_req,
  output logic       sof,
  output logic       byte_done,
  output logic [7:0] byte_val,
  output logic       frame_end,
  output logic       crc_en,
  output logic       crc_dat
);

  rx_state_e  st;
  logic [7:0] win;
  logic [7:0] win_nxt;
  logic [2:0] bitcnt;

  always_comb begin
    win_nxt   = push_bit(win, rxd);
    sof       = (st == ST_HUNT) && crs && (win_nxt == SFD_OCTET);
    byte_done = (st == ST_DATA) && crs && (bitcnt == 3'd7);
    byte_val  = win_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_HUNT;
      win       <= '0;
      bitcnt    <= '0;
      frame_end <= 1'b0;
      crc_en    <= 1'b0;
      crc_dat   <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      crc_en    <= 1'b0;
      if (!crs) begin
        win    <= '0;
        bitcnt <= '0;
        if (st != ST_HUNT) frame_end <= 1'b1;
        st     <= ST_HUNT;
      end else begin
        case (st)
          ST_HUNT: begin
            win <= win_nxt;
            if (sof) begin
              st     <= ST_DATA;
              bitcnt <= '0;
            end
          end
          ST_DATA: begin
            win     <= win_nxt;
            bitcnt  <= bitcnt + 3'd1;
            crc_en  <= 1'b1;
            crc_dat <= rxd;
            if (drop_req) st <= ST_DROP;
          end
          default: st <= ST_DROP;
        endcase
      end
    end
  end

  p_idle_without_carrier_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !crs |=> (st == ST_HUNT));
  p_frame_end_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);
  p_crc_needs_carrier_r10: assert property (@(posedge clk) disable iff (!rst_n)
    crc_en |-> $past(crs));

endmodule

// File: rtl/rxd_addr_filter.sv
module rxd_addr_filter
  import rxd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sof,
  input  logic        byte_done,
  input  logic [7:0]  byte_val,
  input  logic [47:0] station_addr,
  output logic        reject
);

  localparam int IW = $clog2(ADDR_OCTETS + 1);

  logic [IW-1:0] idx;
  logic          uc_ok, bc_ok, hit_uc, hit_bc, judging, last_octet;

  always_comb begin
    judging    = byte_done && (idx < IW'(ADDR_OCTETS));
    last_octet = (idx == IW'(ADDR_OCTETS - 1));
    hit_uc     = uc_ok && (byte_val == addr_octet(station_addr, int'(idx)));
    hit_bc     = bc_ok && (byte_val == 8'hFF);
    reject     = judging && last_octet && !(hit_uc || hit_bc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= IW'(ADDR_OCTETS);
      uc_ok <= 1'b0;
      bc_ok <= 1'b0;
    end else if (sof) begin
      idx   <= '0;
      uc_ok <= 1'b1;
      bc_ok <= 1'b1;
    end else if (judging) begin
      idx   <= idx + 1'b1;
      uc_ok <= hit_uc;
      bc_ok <= hit_bc;
    end
  end

  p_reject_ends_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (idx == IW'(ADDR_OCTETS)));

endmodule

// File: rtl/rxd_byte_fifo.sv
module rxd_byte_fifo #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic [7:0]               wr_data,
  input  logic                     rd_en,
  output logic [7:0]               rd_data,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     full,
  output logic                     empty
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = (level == LW'(DEPTH));
    empty   = (level == '0);
    do_wr   = wr_en && !full;
    do_rd   = rd_en && !empty;
    rd_data = mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (do_wr && !flush) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_wr) wptr <= bump(wptr);
      if (do_rd) rptr <= bump(rptr);
      level <= level + LW'(do_wr) - LW'(do_rd);
    end
  end

  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

endmodule

// File: rtl/rx_deserializer.sv
module rx_deserializer #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 11
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         crs,
  input  logic                         rxd,
  input  logic [47:0]                  station_addr,
  input  logic                         rd_en,
  output logic [7:0]                   rd_data,
  output logic                         fifo_empty,
  output logic [$clog2(FIFO_DEPTH):0]  fifo_level,
  output logic [CNT_W-1:0]             byte_cnt,
  output logic                         overflow,
  output logic                         frame_end,
  output logic                         crc_en,
  output logic                         crc_dat
);

  logic       sof, byte_done, reject, fifo_full, wr_en;
  logic [7:0] byte_val;

  rxd_framer u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .crs       (crs),
    .rxd       (rxd),
    .drop_req  (reject),
    .sof       (sof),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .frame_end (frame_end),
    .crc_en    (crc_en),
    .crc_dat   (crc_dat)
  );

  rxd_addr_filter u_filter (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof          (sof),
    .byte_done    (byte_done),
    .byte_val     (byte_val),
    .station_addr (station_addr),
    .reject       (reject)
  );

  assign wr_en = byte_done && !reject;

  rxd_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (reject),
    .wr_en   (wr_en),
    .wr_data (byte_val),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .level   (fifo_level),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || sof) begin
      overflow <= 1'b0;
      byte_cnt <= '0;
    end else if (reject) begin
      byte_cnt <= '0;
    end else if (wr_en) begin
      if (fifo_full) overflow <= 1'b1;
      else           byte_cnt <= byte_cnt + 1'b1;
    end
  end

  p_lost_byte_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_full) |=> overflow);
  p_count_tracks_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fifo_full) |=> (byte_cnt == CNT_W'($past(byte_cnt) + 1'b1)));
  p_sof_resets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (!overflow && byte_cnt == '0));

endmodule

// File: tb/tb_rx_deserializer.sv
module tb_rx_deserializer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        crs = 1'b0;
  logic        rxd = 1'b0;
  logic [47:0] station_addr = 48'h665544332211;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        fifo_empty;
  logic [4:0]  fifo_level;
  logic [10:0] byte_cnt;
  logic        overflow, frame_end, crc_en, crc_dat;

  int n_run = 0;
  int n_fail = 0;
  int crc_cnt = 0;
  logic [7:0] crc_sr = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  rx_deserializer dut (
    .clk(clk), .rst_n(rst_n), .crs(crs), .rxd(rxd), .station_addr(station_addr),
    .rd_en(rd_en), .rd_data(rd_data), .fifo_empty(fifo_empty), .fifo_level(fifo_level),
    .byte_cnt(byte_cnt), .overflow(overflow), .frame_end(frame_end),
    .crc_en(crc_en), .crc_dat(crc_dat)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic c, input logic b);
    @(negedge clk);
    crs = c;
    rxd = b;
    @(posedge clk);
    #2;
    if (crc_en) begin
      crc_cnt++;
      crc_sr = {crc_dat, crc_sr[7:1]};
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(1'b1, v[i]);
  endtask

  task automatic send_preamble();
    for (int i = 0; i < 7; i++) send_byte(8'h55);
    send_byte(8'hD5);
  endtask

  task automatic send_station();
    for (int k = 0; k < 6; k++) send_byte(station_addr[8*k +: 8]);
  endtask

  task automatic end_frame(input string req);
    send_bit(1'b0, 1'b0);
    chk(req, int'(frame_end), 1);
    send_bit(1'b0, 1'b0);
    chk(req, int'(frame_end), 0);
  endtask

  task automatic pop(output logic [7:0] v);
    @(negedge clk);
    v = rd_data;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic drain();
    logic [7:0] v;
    for (int g = 0; g < 40 && !fifo_empty; g++) pop(v);
  endtask

  task automatic t_reset();
    chk("R4 empty after reset", int'(fifo_empty), 1);
    chk("R4 level after reset", int'(fifo_level), 0);
    chk("R5 count after reset", int'(byte_cnt), 0);
    chk("R9 overflow after reset", int'(overflow), 0);
    chk("R8 frame_end after reset", int'(frame_end), 0);
  endtask

  task automatic t_unicast();
    logic [7:0] v;
    crc_cnt = 0;
    send_preamble();
    send_station();
    for (int i = 0; i < 4; i++) send_byte(8'hA0 + 8'(i));
    chk("R3 level after unicast", int'(fifo_level), 10);
    chk("R5 count after unicast", int'(byte_cnt), 10);
    chk("R10 crc bit count", crc_cnt, 80);
    chk("R10 crc last byte", int'(crc_sr), 'hA3);
    end_frame("R8 unicast end");
    for (int k = 0; k < 6; k++) begin
      pop(v);
      chk("R6 R3 address byte order", int'(v), int'(station_addr[8*k +: 8]));
    end
    for (int i = 0; i < 4; i++) begin
      pop(v);
      chk("R4 payload order", int'(v), 'hA0 + i);
    end
    chk("R4 empty after drain", int'(fifo_empty), 1);
  endtask

  task automatic t_broadcast();
    logic [7:0] v;
    send_preamble();
    for (int k = 0; k < 6; k++) send_byte(8'hFF);
    send_byte(8'h3C);
    send_byte(8'hC3);
    chk("R6 broadcast kept", int'(fifo_level), 8);
    end_frame("R8 broadcast end");
    for (int k = 0; k < 6; k++) pop(v);
    pop(v);
    chk("R3 broadcast payload", int'(v), 'h3C);
    drain();
  endtask

  task automatic t_reject();
    int c0;
    send_preamble();
    send_station();
    send_byte(8'h01);
    send_byte(8'h02);
    end_frame("R8 first frame end");
    chk("R7 leftover present", int'(fifo_level), 8);
    send_preamble();
    for (int k = 0; k < 5; k++)
      send_byte(k == 3 ? 8'h99 : station_addr[8*k +: 8]);
    chk("R7 before sixth byte", int'(fifo_level), 13);
    chk("R5 count before sixth", int'(byte_cnt), 5);
    send_byte(station_addr[47:40]);
    chk("R7 flush at sixth byte", int'(fifo_level), 0);
    chk("R5 count cleared by reject", int'(byte_cnt), 0);
    c0 = crc_cnt;
    for (int i = 0; i < 3; i++) send_byte(8'h77);
    chk("R7 later bytes not stored", int'(fifo_level), 0);
    chk("R10 no crc after reject", crc_cnt, c0);
    end_frame("R8 rejected frame end");
  endtask

  task automatic t_partial();
    send_preamble();
    send_station();
    send_byte(8'h5A);
    send_bit(1'b1, 1'b1);
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b1);
    end_frame("R8 partial drop pulse");
    chk("R8 partial byte discarded", int'(fifo_level), 7);
    drain();
  endtask

  task automatic t_carrier_gate();
    int c0;
    c0 = crc_cnt;
    for (int i = 0; i < 7; i++)
      for (int b = 0; b < 8; b++) send_bit(1'b0, b[0] ? 1'b0 : 1'b1);
    for (int b = 0; b < 8; b++) send_bit(1'b0, 1'(8'hD5 >> b));
    for (int i = 0; i < 8; i++)
      for (int b = 0; b < 8; b++) send_bit(1'b0, 1'b0);
    chk("R1 nothing without carrier", int'(fifo_level), 0);
    chk("R1 no crc without carrier", crc_cnt, c0);
    for (int i = 0; i < 7; i++) send_byte(8'h55);
    for (int b = 0; b < 4; b++) send_bit(1'b1, 1'(8'hD5 >> b));
    send_bit(1'b0, 1'b0);
    for (int b = 4; b < 8; b++) send_bit(1'b1, 1'(8'hD5 >> b));
    for (int i = 0; i < 8; i++) send_byte(8'h00);
    chk("R2 split delimiter ignored", int'(fifo_level), 0);
    chk("R2 split delimiter no crc", crc_cnt, c0);
    send_bit(1'b0, 1'b0);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    send_preamble();
    send_station();
    for (int i = 0; i < 12; i++) send_byte(8'h80 + 8'(i));
    chk("R9 fifo full", int'(fifo_level), 16);
    chk("R9 overflow set", int'(overflow), 1);
    chk("R5 count stops at writes", int'(byte_cnt), 16);
    end_frame("R8 overflow frame end");
    chk("R9 overflow sticky", int'(overflow), 1);
    send_preamble();
    chk("R2 delimiter clears overflow", int'(overflow), 0);
    chk("R2 delimiter clears count", int'(byte_cnt), 0);
    send_bit(1'b0, 1'b0);
    for (int k = 0; k < 6; k++) pop(v);
    for (int i = 0; i < 10; i++) begin
      pop(v);
      chk("R9 kept bytes intact", int'(v), 'h80 + i);
    end
    chk("R9 lost bytes absent", int'(fifo_empty), 1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    t_reset();
    t_unicast();
    t_broadcast();
    t_reject();
    t_partial();
    t_carrier_gate();
    t_overflow();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule